// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block arbitrates among a parameterised set of level-sensitive interrupt request lines plus two fixed high-ranked inputs, a non-maskable request and a hard-fault request. Each configurable source has an enable bit and a 4-bit raw priority. A shared group selector divides every raw priority into two fields. The upper field is the preemption level and decides nesting. The lower field is the sub-priority and only breaks ties.

Each cycle the block picks the best eligible request and registers it as a grant. It records the granted source on a LIFO of active handlers. The running level follows the top of that LIFO, so a new request can interrupt the running handler only when its preemption level is strictly higher. Software ends a handler with a one-cycle completion pulse, which pops the LIFO and restores the level of the handler below. Two global mask inputs lower the running ceiling. The first admits only the two fixed inputs. The second admits the non-maskable request alone.

Top module: `nest_irq_arbiter`

## Requirements
- R1: With group value g (values above 4 act as 4), the preemption field is the top g bits of a source's raw priority (none when g is 0) and the sub-priority is the remaining low bits.
- R2: The grant is registered: `grant_valid` is high for one cycle, in the cycle after an eligible request wins. `grant_id` is the source index 0..NUM_SRC-1, NUM_SRC for hard fault, or NUM_SRC+1 for the non-maskable request.
- R3: Among eligible requests, the smaller preemption level wins. On equal levels, the smaller sub-priority wins. On equal levels and sub-priorities, the lower source index wins.
- R4: A request is granted while a handler runs only if its level is strictly below `cur_level`; a request at an equal level waits. `grant_preempt` is 1 when the grant nests over an active handler.
- R5: `cur_level` is 31 when no handler is active, 0 for the non-maskable handler, 1 for hard fault and 2 plus the preemption field for a configurable source. It always reflects the top of the active LIFO.
- R6: A `handler_done` pulse pops one active entry. A cycle with `handler_done` high grants nothing. `handler_done` with no active handler changes nothing.
- R7: A source whose enable bit is 0 is never granted, even with its request high.
- R8: With `mask_normal` high, only the hard-fault and non-maskable inputs can be granted.
- R9: With `mask_fault` high, only the non-maskable input can be granted.
- R10: A change of the group selector takes effect at once on `cur_level` and on the next arbitration, for active and pending sources alike.
- R11: The LIFO holds STACK_DEPTH entries. When it is full, no grant is made until an entry is popped.
- R12: After reset, `grant_valid` is 0, `nest_depth` is 0 and `cur_level` is 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | NUM_SRC | Level request per configurable source |
| irq_en | input | NUM_SRC | Enable per configurable source |
| irq_prio | input | NUM_SRC*4 | Raw 4-bit priority per source, source i at bits [4i+3:4i] |
| prio_group | input | 3 | Split selector between preemption and sub-priority fields |
| nmi_req | input | 1 | Non-maskable request |
| fault_req | input | 1 | Hard-fault request |
| mask_normal | input | 1 | Global mask admitting only hard fault and non-maskable |
| mask_fault | input | 1 | Global mask admitting only non-maskable |
| handler_done | input | 1 | End-of-handler pulse |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_id | output | clog2(NUM_SRC+2) | Index of the granted request |
| grant_preempt | output | 1 | Grant nests over an active handler |
| cur_level | output | 5 | Running preemption level |
| nest_depth | output | clog2(STACK_DEPTH+1) | Number of active handlers |

## Verification
Two sources with the same preemption level but different sub-priorities are raised together, and then two with identical raw priorities. These show that the sub-priority and then the index decide, without either causing nesting. Same-level and higher-level requests are raised while a handler runs, which separates waiting from preemption. Sequences with one mask or both masks set, with a disabled source and with fixed-input requests distinguish the two mask ceilings. A group selector swept across 0, 1, 3, 4 and 7 while a handler stays active shows the field split, the clamp and the live reinterpretation. A staircase of ever-higher requests fills the LIFO and shows that a further grant is held back until one pop frees a slot.

// File: rtl/nia_pkg.sv
// Shared constants and types for the nested interrupt arbiter.
// Assumes a 4-bit raw priority; level encoding: 0 non-maskable,
// 1 hard fault, 2.. configurable, all ones idle.
package nia_pkg;
    localparam int PRIO_W = 4;
    localparam int GRP_W  = $clog2(PRIO_W + 1);
    localparam int LVL_W  = $clog2((1 << PRIO_W) + 3);

    localparam logic [LVL_W-1:0] LVL_NMI   = LVL_W'(0);
    localparam logic [LVL_W-1:0] LVL_FAULT = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_BASE  = LVL_W'(2);
    localparam logic [LVL_W-1:0] LVL_IDLE  = {LVL_W{1'b1}};

    // Rank of one candidate; a smaller packed value is a better candidate.
    typedef struct packed {
        logic [LVL_W-1:0]  lvl;
        logic [PRIO_W-1:0] sub;
    } rank_t;
endpackage

// File: rtl/prio_split.sv
// Splits one raw priority into preemption level and sub-priority
// under the current group selector. Purely combinational.
// Assumes selector values above PRIO_W behave as PRIO_W.
module prio_split
    import nia_pkg::*;
(
    input  logic [PRIO_W-1:0] prio,
    input  logic [GRP_W-1:0]  grp,
    output rank_t             rank
);
    logic [GRP_W-1:0]  g_eff;
    logic [PRIO_W-1:0] pre_field;
    logic [PRIO_W-1:0] sub_mask;

    // Clamp the selector and carve the two fields out of the raw value.
    always_comb begin
        g_eff     = (grp > GRP_W'(PRIO_W)) ? GRP_W'(PRIO_W) : grp;
        sub_mask  = PRIO_W'((1 << (PRIO_W - int'(g_eff))) - 1);
        pre_field = (g_eff == '0) ? '0 : PRIO_W'(prio >> (PRIO_W - int'(g_eff)));
        rank.lvl  = LVL_BASE + LVL_W'(pre_field);
        rank.sub  = prio & sub_mask;
    end
endmodule

// File: rtl/rank_select.sv
// Picks the best candidate whose level is strictly below a ceiling.
// Smaller {level, sub} wins; ties go to the lower index.
// Assumes candidates are ordered by index, fixed inputs last.
module rank_select
    import nia_pkg::*;
#(
    parameter int NUM_CAND = 10,
    parameter int IDX_W    = $clog2(NUM_CAND)
) (
    input  logic [NUM_CAND-1:0] cand_valid,
    input  rank_t               cand_rank [NUM_CAND],
    input  logic [LVL_W-1:0]    ceiling,
    output logic                win_valid,
    output logic [IDX_W-1:0]    win_idx,
    output rank_t               win_rank
);
    // Linear scan keeping the strictly better candidate.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_rank  = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
            if (cand_valid[i] && (cand_rank[i].lvl < ceiling) &&
                (!win_valid || (cand_rank[i] < win_rank))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_rank  = cand_rank[i];
            end
        end
    end
endmodule

// File: rtl/nest_stack.sv
// LIFO of active handler identifiers. Push and pop are never
// requested together; the parent gates them. Assumes DEPTH >= 2.
module nest_stack #(
    parameter int DEPTH = 6,
    parameter int ID_W  = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [ID_W-1:0]  push_id,
    output logic [ID_W-1:0]  top_id,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [ID_W-1:0]  mem [DEPTH];
    logic [CNT_W-1:0] top_ptr;

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (push) count <= count + CNT_W'(1);
        else if (pop)  count <= count - CNT_W'(1);
    end

    // Entry storage, written at the current occupancy.
    always_ff @(posedge clk) begin
        if (push) mem[count[PTR_W-1:0]] <= push_id;
    end

    // Status and top-of-stack read.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        top_ptr = count - CNT_W'(1);
        top_id  = empty ? '0 : mem[top_ptr[PTR_W-1:0]];
    end

    a_r11_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> count == $past(count) - CNT_W'(1));
    a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/nest_irq_arbiter.sv
// Grouped-priority nested interrupt arbiter (top).
// Builds ranks for all candidates, selects against a ceiling formed
// from the running level and the global masks, registers the grant
// and tracks active handlers on a LIFO. Requests are level-sensitive
// and are expected to drop once serviced.
module nest_irq_arbiter
    import nia_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int STACK_DEPTH = 6,
    parameter int ID_W        = $clog2(NUM_SRC + 2),
    parameter int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        irq_req,
    input  logic [NUM_SRC-1:0]        irq_en,
    input  logic [NUM_SRC*PRIO_W-1:0] irq_prio,
    input  logic [GRP_W-1:0]          prio_group,
    input  logic                      nmi_req,
    input  logic                      fault_req,
    input  logic                      mask_normal,
    input  logic                      mask_fault,
    input  logic                      handler_done,
    output logic                      grant_valid,
    output logic [ID_W-1:0]           grant_id,
    output logic                      grant_preempt,
    output logic [LVL_W-1:0]          cur_level,
    output logic [CNT_W-1:0]          nest_depth
);
    localparam int NUM_CAND = NUM_SRC + 2;
    localparam int ID_FAULT = NUM_SRC;
    localparam int ID_NMI   = NUM_SRC + 1;

    logic [NUM_CAND-1:0] cand_valid;
    rank_t               cand_rank [NUM_CAND];
    logic [LVL_W-1:0]    ceiling;
    logic                sel_valid;
    logic [ID_W-1:0]     sel_idx;
    rank_t               sel_rank;
    logic                do_push;
    logic                do_pop;
    logic [ID_W-1:0]     top_id;
    logic                stk_empty;
    logic                stk_full;
    logic [LVL_W-1:0]    grant_lvl_q;

    // One rank builder per configurable source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        prio_split u_split (
            .prio (irq_prio[i*PRIO_W +: PRIO_W]),
            .grp  (prio_group),
            .rank (cand_rank[i])
        );
        assign cand_valid[i] = irq_req[i] & irq_en[i];
    end

    // Fixed-rank inputs sit after the configurable sources.
    assign cand_valid[ID_FAULT] = fault_req;
    assign cand_rank[ID_FAULT]  = '{lvl: LVL_FAULT, sub: '0};
    assign cand_valid[ID_NMI]   = nmi_req;
    assign cand_rank[ID_NMI]    = '{lvl: LVL_NMI, sub: '0};

    // Running level from the active top, reinterpreted under the live split.
    always_comb begin
        cur_level = LVL_IDLE;
        if (!stk_empty) begin
            for (int i = 0; i < NUM_CAND; i++) begin
                if (top_id == ID_W'(i)) cur_level = cand_rank[i].lvl;
            end
        end
    end

    // Ceiling: running level lowered by the global masks.
    always_comb begin
        ceiling = cur_level;
        if (mask_normal && (ceiling > LVL_BASE))  ceiling = LVL_BASE;
        if (mask_fault && (ceiling > LVL_FAULT)) ceiling = LVL_FAULT;
    end

    rank_select #(
        .NUM_CAND (NUM_CAND),
        .IDX_W    (ID_W)
    ) u_select (
        .cand_valid (cand_valid),
        .cand_rank  (cand_rank),
        .ceiling    (ceiling),
        .win_valid  (sel_valid),
        .win_idx    (sel_idx),
        .win_rank   (sel_rank)
    );

    // Stack control: completion has precedence and suppresses a grant.
    always_comb begin
        do_pop  = handler_done && !stk_empty;
        do_push = sel_valid && !handler_done && !stk_full;
    end

    nest_stack #(
        .DEPTH (STACK_DEPTH),
        .ID_W  (ID_W),
        .CNT_W (CNT_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (do_push),
        .pop     (do_pop),
        .push_id (sel_idx),
        .top_id  (top_id),
        .count   (nest_depth),
        .empty   (stk_empty),
        .full    (stk_full)
    );

    // Registered grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid   <= 1'b0;
            grant_id      <= '0;
            grant_preempt <= 1'b0;
            grant_lvl_q   <= LVL_IDLE;
        end else begin
            grant_valid   <= do_push;
            grant_id      <= sel_idx;
            grant_preempt <= do_push && !stk_empty;
            grant_lvl_q   <= sel_rank.lvl;
        end
    end

    a_r9_fault_mask_nmi_only: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(mask_fault)) |-> grant_id == ID_W'(ID_NMI));
    a_r8_normal_mask_fixed_only: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(mask_normal)) |-> grant_id >= ID_W'(ID_FAULT));
    a_r4_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_lvl_q < $past(cur_level));
    a_r7_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && (grant_id < ID_W'(NUM_SRC))) |->
        (|(($past(irq_en) >> grant_id) & NUM_SRC'(1))));
    a_r2_grant_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> nest_depth == $past(nest_depth) + CNT_W'(1));
endmodule

// File: tb/tb_nest_irq_arbiter.sv
`timescale 1ns/1ps
module tb_nest_irq_arbiter;
    localparam int N     = 8;
    localparam int DEPTH = 6;

    typedef struct {
        bit    v;
        int    id;
        bit    pre;
        int    depth;
        int    lvl;
        string req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   irq_req;
    logic [N-1:0]   irq_en;
    logic [3:0]     prio_a [N];
    logic [N*4-1:0] irq_prio;
    logic [2:0]     prio_group;
    logic           nmi_req, fault_req, mask_normal, mask_fault, handler_done;
    logic           grant_valid;
    logic [3:0]     grant_id;
    logic           grant_preempt;
    logic [4:0]     cur_level;
    logic [2:0]     nest_depth;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) irq_prio[i*4 +: 4] = prio_a[i];
    end

    nest_irq_arbiter #(.NUM_SRC(N), .STACK_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .irq_prio(irq_prio), .prio_group(prio_group), .nmi_req(nmi_req),
        .fault_req(fault_req), .mask_normal(mask_normal), .mask_fault(mask_fault),
        .handler_done(handler_done), .grant_valid(grant_valid), .grant_id(grant_id),
        .grant_preempt(grant_preempt), .cur_level(cur_level), .nest_depth(nest_depth)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: queue the expectation for the coming edge, then move one cycle.
    task automatic step(input bit v, input int id, input bit pre,
                        input int depth, input int lvl, input string req);
        exp_t e;
        e.v = v; e.id = id; e.pre = pre; e.depth = depth; e.lvl = lvl; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compare outputs shortly after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(grant_valid == e.v, e.req, "grant_valid", int'(grant_valid), int'(e.v));
                if (e.v) begin
                    check(int'(grant_id) == e.id, e.req, "grant_id", int'(grant_id), e.id);
                    check(grant_preempt == e.pre, e.req, "grant_preempt",
                          int'(grant_preempt), int'(e.pre));
                end
                check(int'(nest_depth) == e.depth, e.req, "nest_depth", int'(nest_depth), e.depth);
                check(int'(cur_level) == e.lvl, e.req, "cur_level", int'(cur_level), e.lvl);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; irq_en = '1; prio_group = 3'd2;
        nmi_req = 0; fault_req = 0; mask_normal = 0; mask_fault = 0; handler_done = 0;
        for (int i = 0; i < N; i++) prio_a[i] = 4'hF;
        irq_req[2] = 1'b1; prio_a[2] = 4'h0;
        repeat (3) @(negedge clk);
        // R12 reset state, even with a request pending
        check(grant_valid == 1'b0, "R12", "grant_valid", int'(grant_valid), 0);
        check(nest_depth == 3'd0, "R12", "nest_depth", int'(nest_depth), 0);
        check(cur_level == 5'd31, "R12", "cur_level", int'(cur_level), 31);
        rst_n = 1'b1; irq_req[2] = 1'b0; prio_a[2] = 4'hF;

        step(0, 0, 0, 0, 31, "R5");
        // R3 same level, sub-priority decides (group 2)
        prio_a[3] = 4'b0110; prio_a[5] = 4'b0101; irq_req[3] = 1; irq_req[5] = 1;
        step(1, 5, 0, 1, 3, "R3");
        step(0, 0, 0, 1, 3, "R4");
        prio_a[1] = 4'b0111; irq_req[1] = 1;
        step(0, 0, 0, 1, 3, "R4");
        // R4 strictly higher level preempts
        prio_a[6] = 4'b0011; irq_req[6] = 1;
        step(1, 6, 1, 2, 2, "R4");
        handler_done = 1; irq_req[6] = 0;
        step(0, 0, 0, 1, 3, "R6");
        irq_req[5] = 0;
        step(0, 0, 0, 0, 31, "R6");
        handler_done = 0;
        step(1, 3, 0, 1, 3, "R3");
        handler_done = 1; irq_req[3] = 0;
        step(0, 0, 0, 0, 31, "R6");
        // R3 full tie, lower index wins
        handler_done = 0; prio_a[1] = 4'b1000; prio_a[4] = 4'b1000; irq_req[4] = 1;
        step(1, 1, 0, 1, 4, "R3");
        handler_done = 1; irq_req[1] = 0; irq_req[4] = 0;
        step(0, 0, 0, 0, 31, "R6");
        // R7 disabled source
        handler_done = 0; irq_en[2] = 0; prio_a[2] = 4'h0; irq_req[2] = 1;
        step(0, 0, 0, 0, 31, "R7");
        irq_en[2] = 1;
        step(1, 2, 0, 1, 2, "R7");
        handler_done = 1; irq_req[2] = 0;
        step(0, 0, 0, 0, 31, "R6");
        // R8 normal mask
        handler_done = 0; mask_normal = 1; prio_a[0] = 4'h0; irq_req[0] = 1; fault_req = 1;
        step(1, 8, 0, 1, 1, "R8");
        step(0, 0, 0, 1, 1, "R8");
        nmi_req = 1;
        step(1, 9, 1, 2, 0, "R8");
        handler_done = 1; nmi_req = 0;
        step(0, 0, 0, 1, 1, "R6");
        fault_req = 0;
        step(0, 0, 0, 0, 31, "R6");
        // R9 fault mask blocks hard fault
        handler_done = 0; mask_fault = 1; fault_req = 1;
        step(0, 0, 0, 0, 31, "R9");
        nmi_req = 1;
        step(1, 9, 0, 1, 0, "R9");
        handler_done = 1; nmi_req = 0;
        step(0, 0, 0, 0, 31, "R6");
        handler_done = 0; mask_fault = 0; mask_normal = 0; fault_req = 0;
        step(1, 0, 0, 1, 2, "R2");
        handler_done = 1; irq_req[0] = 0;
        step(0, 0, 0, 0, 31, "R6");
        // R1 / R10 group split and live reinterpretation
        handler_done = 0; prio_group = 3'd4; prio_a[3] = 4'b0100; irq_req[3] = 1;
        step(1, 3, 0, 1, 6, "R1");
        prio_group = 3'd0; prio_a[7] = 4'h0; irq_req[7] = 1;
        step(0, 0, 0, 1, 2, "R10");
        prio_group = 3'd4;
        step(1, 7, 1, 2, 2, "R10");
        handler_done = 1; irq_req[7] = 0;
        step(0, 0, 0, 1, 6, "R10");
        handler_done = 0; prio_group = 3'd1;
        step(0, 0, 0, 1, 2, "R1");
        prio_group = 3'd3;
        step(0, 0, 0, 1, 4, "R1");
        prio_group = 3'd7;
        step(0, 0, 0, 1, 6, "R1");
        handler_done = 1; irq_req = '0; prio_group = 3'd4;
        step(0, 0, 0, 0, 31, "R6");
        step(0, 0, 0, 0, 31, "R6");
        // R11 fill the LIFO with ever-higher requests
        handler_done = 0;
        prio_a[7] = 4'd14; prio_a[6] = 4'd12; prio_a[5] = 4'd10;
        prio_a[4] = 4'd8;  prio_a[3] = 4'd6;  prio_a[2] = 4'd4; prio_a[1] = 4'd2;
        irq_req[7] = 1; step(1, 7, 0, 1, 16, "R11");
        irq_req[6] = 1; step(1, 6, 1, 2, 14, "R11");
        irq_req[5] = 1; step(1, 5, 1, 3, 12, "R11");
        irq_req[4] = 1; step(1, 4, 1, 4, 10, "R11");
        irq_req[3] = 1; step(1, 3, 1, 5, 8, "R11");
        irq_req[2] = 1; step(1, 2, 1, 6, 6, "R11");
        irq_req[1] = 1; step(0, 0, 0, 6, 6, "R11");
        handler_done = 1; irq_req[2] = 0;
        step(0, 0, 0, 5, 8, "R11");
        handler_done = 0;
        step(1, 1, 1, 6, 4, "R11");
        step(0, 0, 0, 6, 4, "R4");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule